// File: doc/BRIEF.md
# Per-CPU Priority Interrupt Selector

This block sits on the CPU side of a small interrupt controller. The distributor owns the enable, pending, priority, target and trigger-mode state and presents it on ports. For every CPU the block reduces the interrupts that are both enabled and pending to one winner. It weighs that winner against the CPU's priority mask and the priority of the interrupt it is servicing, and drives a registered interrupt line to that CPU.

Software reaches each CPU's interface through one shared register port. A `reg_cpu_i` field selects the CPU. Reads return data combinationally in the same cycle as the strobe, and their side effects take place at the clock edge. An acknowledge read claims the winning interrupt and pulses a pending-clear request back to the pending-state owner. An end-of-interrupt write retires an active interrupt and can pulse a pending-set request. Every CPU keeps a linked stack of preempted interrupts. Completion may therefore happen in any order, and completing an interrupt that is not the running one removes it from the stack.

Top module: `irq_cpu_arbiter`

## Requirements
- R1: After reset each CPU has no running interrupt, so its running priority reads 0x100 and its highest-pending value reads 1023. Its interrupt line is low, its interface is disabled and its priority mask is 0.
- R2: The candidates are the interrupts that are enabled and pending for the CPU. The one with the numerically smallest priority wins, and on equal priority the lowest index wins.
- R3: The highest-pending value (offset 0x18) is the winner's ID only when the winner's priority is strictly below the priority mask, and 1023 otherwise. The CPU line also needs that priority to be strictly below the running priority, and it follows one clock after the state it depends on.
- R4: When the global enable or the CPU's interface enable (offset 0x00, bit 0) is low, the highest-pending value is 1023 and the CPU line is low.
- R5: A read of offset 0x0C returns 1023, with no effect, when there is no highest-pending interrupt or its priority is not below the running priority. Otherwise it returns the ID and makes that interrupt running with its priority, and the previous running ID becomes the new interrupt's predecessor.
- R6: An acknowledge asks for the pending bit to be cleared for every CPU when the interrupt's one-of-N flag is 1. When the flag is 0 it asks only for the acknowledging CPU.
- R7: A write to offset 0x10 takes the interrupt ID from write-data bits [9:0]. It does nothing when the ID is at least NUM_IRQ or when no interrupt is running.
- R8: A completion asks to set the pending bit again for a level-sensitive interrupt (edge flag 0) that is still enabled, still asserted and targeted at this CPU. An edge-triggered interrupt is not re-pended.
- R9: Completing the running interrupt makes its recorded predecessor the running interrupt, with that interrupt's priority, or returns the CPU to idle (1023 / 0x100) when there is none.
- R10: Completing an active interrupt that is not running removes it from the preempted stack and leaves the running interrupt and the running priority unchanged.
- R11: Offset 0x04 holds an 8-bit priority mask. Offset 0x08 reads as zero and ignores writes, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glob_en_i | input | 1 | Global forwarding enable from the distributor |
| en_i | input | NUM_CPU x NUM_IRQ | Enable bit per CPU and interrupt |
| pend_i | input | NUM_CPU x NUM_IRQ | Pending bit per CPU and interrupt |
| level_i | input | NUM_CPU x NUM_IRQ | Current input level per CPU and interrupt |
| target_i | input | NUM_CPU x NUM_IRQ | Interrupt is routed to that CPU |
| edge_cfg_i | input | NUM_IRQ | 1 = edge-triggered, 0 = level-sensitive |
| one_of_n_i | input | NUM_IRQ | 1 = acknowledging on one CPU clears it for all |
| prio_i | input | NUM_IRQ x 8 | Priority per interrupt, lower is more urgent |
| reg_cpu_i | input | CPU_W | CPU interface selected by the access |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Byte offset inside the CPU interface |
| reg_wdata_i | input | 10 | Write data (control bit 0, mask [7:0], completion ID [9:0]) |
| reg_rdata_o | output | 32 | Read data, valid in the strobe cycle |
| cpu_irq_o | output | NUM_CPU | Registered interrupt line per CPU |
| pend_clr_o | output | NUM_CPU x NUM_IRQ | One-cycle pending-clear request |
| pend_set_o | output | NUM_CPU x NUM_IRQ | One-cycle pending-set request |

## Verification
The bench builds a nest three deep and then retires the middle interrupt first. A design that restored the wrong predecessor would then report priority 0x20 instead of 0x40 when the top interrupt completes, and a design that popped the stack on every completion would report a running priority change at the middle completion. Ties of equal priority, masks sitting exactly on the winner's priority, and a pending interrupt at the running priority are each probed, because an off-by-one in a strict comparison shows up only there. The clear scope of acknowledges is checked on both a one-of-N interrupt and a per-CPU interrupt. Level re-pending is checked with the line high, with the line low and with no interrupt running, so a design that re-pended unconditionally or ignored the idle case would leave a stray pending bit.

// File: rtl/prisel_pkg.sv
package prisel_pkg;

    localparam int          ID_W       = 10;
    localparam int          RPRIO_W    = 9;
    localparam logic [9:0]  ID_NONE    = 10'd1023;
    localparam logic [8:0]  PRIO_IDLE  = 9'h100;

    typedef logic [ID_W-1:0]    irq_id_t;
    typedef logic [RPRIO_W-1:0] rprio_t;

    // one arbitration candidate: ID and widened priority
    typedef struct packed {
        irq_id_t id;
        rprio_t  prio;
    } cand_t;

    typedef enum logic [7:0] {
        OFS_CTRL  = 8'h00,
        OFS_PMASK = 8'h04,
        OFS_BPT   = 8'h08,
        OFS_ACK   = 8'h0C,
        OFS_EOI   = 8'h10,
        OFS_RPRIO = 8'h14,
        OFS_HPEND = 8'h18
    } cpu_reg_e;

    // left operand keeps the win unless right is strictly more urgent
    function automatic cand_t pick(cand_t lo, cand_t hi);
        return (hi.prio < lo.prio) ? hi : lo;
    endfunction

endpackage

// File: rtl/prio_tree.sv
module prio_tree
    import prisel_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic [NUM_IRQ-1:0]      en,
    input  logic [NUM_IRQ-1:0]      pend,
    input  logic [NUM_IRQ-1:0][7:0] prio,
    output cand_t                   best
);
    localparam int LVL    = $clog2(NUM_IRQ);
    localparam int LEAVES = 1 << LVL;

    cand_t node [1:2*LEAVES-1];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NUM_IRQ) begin : g_real
            assign node[LEAVES+i] = (en[i] && pend[i])
                ? cand_t'{id: irq_id_t'(i), prio: {1'b0, prio[i]}}
                : cand_t'{id: ID_NONE, prio: PRIO_IDLE};
        end else begin : g_pad
            assign node[LEAVES+i] = cand_t'{id: ID_NONE, prio: PRIO_IDLE};
        end
    end

    for (genvar k = 1; k < LEAVES; k++) begin : g_node
        assign node[k] = pick(node[2*k], node[2*k+1]);
    end

    assign best = node[1];

endmodule

// File: rtl/cpu_port.sv
module cpu_port
    import prisel_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    glob_en,
    input  logic [NUM_IRQ-1:0]      en_row,
    input  logic [NUM_IRQ-1:0]      level_row,
    input  logic [NUM_IRQ-1:0]      tgt_row,
    input  logic [NUM_IRQ-1:0]      edge_cfg,
    input  logic [NUM_IRQ-1:0][7:0] prio,
    input  cand_t                   best,
    input  logic                    sel,
    input  logic                    wr,
    input  logic                    rd,
    input  logic [7:0]              addr,
    input  logic [ID_W-1:0]         wdata,
    output logic [31:0]             rdata,
    output logic                    irq,
    output logic                    clr_v,
    output irq_id_t                 clr_id,
    output logic                    set_v,
    output irq_id_t                 set_id
);
    localparam int IDX_W = $clog2(NUM_IRQ);

    logic                ctl_en;
    logic [7:0]          pmask;
    irq_id_t             run_id;
    rprio_t              run_prio;
    irq_id_t             pred [NUM_IRQ];
    logic [NUM_IRQ-1:0]  active;

    logic                hp_ok, take_int, acc_rd, acc_wr, ack_go, eoi_go, eoi_is_run;
    irq_id_t             hp_id, eoi_id, restore_id;
    rprio_t              restore_prio;
    logic [IDX_W-1:0]    eoi_idx, run_idx, best_idx;
    logic [NUM_IRQ-1:0]  unlink_hit;

    assign acc_rd   = sel && rd;
    assign acc_wr   = sel && wr;
    assign hp_ok    = glob_en && ctl_en && (best.prio < {1'b0, pmask});
    assign hp_id    = hp_ok ? best.id : ID_NONE;
    assign take_int = hp_ok && (best.prio < run_prio);
    assign best_idx = best.id[IDX_W-1:0];

    assign ack_go   = acc_rd && (addr == OFS_ACK) && take_int;

    assign eoi_id     = wdata;
    assign eoi_idx    = eoi_id[IDX_W-1:0];
    assign run_idx    = run_id[IDX_W-1:0];
    assign eoi_go     = acc_wr && (addr == OFS_EOI) && (eoi_id < ID_W'(NUM_IRQ))
                        && (run_id != ID_NONE);
    assign eoi_is_run = (eoi_id == run_id);

    assign restore_id   = pred[run_idx];
    assign restore_prio = (restore_id == ID_NONE) ? PRIO_IDLE
                                                  : {1'b0, prio[restore_id[IDX_W-1:0]]};

    always_comb begin
        for (int j = 0; j < NUM_IRQ; j++) begin
            unlink_hit[j] = active[j] && (pred[j] == eoi_id) && !eoi_is_run;
        end
    end

    assign clr_v  = ack_go;
    assign clr_id = best.id;
    assign set_v  = eoi_go && !edge_cfg[eoi_idx] && en_row[eoi_idx]
                    && level_row[eoi_idx] && tgt_row[eoi_idx];
    assign set_id = eoi_id;

    always_comb begin
        rdata = '0;
        if (acc_rd) begin
            case (addr)
                OFS_CTRL:  rdata = {31'd0, ctl_en};
                OFS_PMASK: rdata = {24'd0, pmask};
                OFS_ACK:   rdata = {22'd0, (take_int ? best.id : ID_NONE)};
                OFS_RPRIO: rdata = {23'd0, run_prio};
                OFS_HPEND: rdata = {22'd0, hp_id};
                default:   rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_en   <= 1'b0;
            pmask    <= '0;
            run_id   <= ID_NONE;
            run_prio <= PRIO_IDLE;
            active   <= '0;
            irq      <= 1'b0;
            for (int j = 0; j < NUM_IRQ; j++) pred[j] <= ID_NONE;
        end else begin
            irq <= take_int;
            if (acc_wr && addr == OFS_CTRL)  ctl_en <= wdata[0];
            if (acc_wr && addr == OFS_PMASK) pmask  <= wdata[7:0];
            if (ack_go) begin
                pred[best_idx]   <= run_id;
                active[best_idx] <= 1'b1;
                run_id           <= best.id;
                run_prio         <= best.prio;
            end
            if (eoi_go) begin
                active[eoi_idx] <= 1'b0;
                if (eoi_is_run) begin
                    run_id   <= restore_id;
                    run_prio <= restore_prio;
                end else begin
                    for (int j = 0; j < NUM_IRQ; j++) begin
                        if (unlink_hit[j]) pred[j] <= pred[eoi_idx];
                    end
                end
            end
        end
    end

    // idle ID and idle priority travel together
    assert_idle_prio_R1: assert property (@(posedge clk) disable iff (rst)
        (run_id == ID_NONE) |-> (run_prio == PRIO_IDLE));

    // line only rises while both enables were high
    assert_irq_gated_R4: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(glob_en && ctl_en));

    // line only rises when the winner beat mask and running priority
    assert_irq_thresh_R3: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(hp_id != ID_NONE));

    // a successful acknowledge always raises urgency
    assert_ack_preempts_R5: assert property (@(posedge clk) disable iff (rst)
        ack_go |=> (run_prio < $past(run_prio)));

    // completion of an out-of-range ID leaves the running interrupt alone
    assert_eoi_range_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && addr == OFS_EOI && eoi_id >= ID_W'(NUM_IRQ)) |=> $stable(run_id));

    // completing the running interrupt moves to a different one
    assert_eoi_pop_R9: assert property (@(posedge clk) disable iff (rst)
        (eoi_go && eoi_is_run) |=> (run_id != $past(run_id)));

    // completing a non-running interrupt keeps the running one
    assert_eoi_unlink_R10: assert property (@(posedge clk) disable iff (rst)
        (eoi_go && !eoi_is_run) |=> ($stable(run_id) && $stable(run_prio)));

endmodule

// File: rtl/irq_cpu_arbiter.sv
module irq_cpu_arbiter
    import prisel_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int NUM_CPU = 4,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             glob_en_i,
    input  logic [NUM_CPU-1:0][NUM_IRQ-1:0]  en_i,
    input  logic [NUM_CPU-1:0][NUM_IRQ-1:0]  pend_i,
    input  logic [NUM_CPU-1:0][NUM_IRQ-1:0]  level_i,
    input  logic [NUM_CPU-1:0][NUM_IRQ-1:0]  target_i,
    input  logic [NUM_IRQ-1:0]               edge_cfg_i,
    input  logic [NUM_IRQ-1:0]               one_of_n_i,
    input  logic [NUM_IRQ-1:0][7:0]          prio_i,
    input  logic [CPU_W-1:0]                 reg_cpu_i,
    input  logic                             reg_wr_i,
    input  logic                             reg_rd_i,
    input  logic [7:0]                       reg_addr_i,
    input  logic [ID_W-1:0]                  reg_wdata_i,
    output logic [31:0]                      reg_rdata_o,
    output logic [NUM_CPU-1:0]               cpu_irq_o,
    output logic [NUM_CPU-1:0][NUM_IRQ-1:0]  pend_clr_o,
    output logic [NUM_CPU-1:0][NUM_IRQ-1:0]  pend_set_o
);
    cand_t               best   [NUM_CPU];
    logic [31:0]         rdata  [NUM_CPU];
    logic [NUM_CPU-1:0]  clr_v, set_v;
    irq_id_t             clr_id [NUM_CPU];
    irq_id_t             set_id [NUM_CPU];

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        prio_tree #(.NUM_IRQ(NUM_IRQ)) u_tree (
            .en   (en_i[c]),
            .pend (pend_i[c]),
            .prio (prio_i),
            .best (best[c])
        );

        cpu_port #(.NUM_IRQ(NUM_IRQ)) u_port (
            .clk       (clk),
            .rst       (rst),
            .glob_en   (glob_en_i),
            .en_row    (en_i[c]),
            .level_row (level_i[c]),
            .tgt_row   (target_i[c]),
            .edge_cfg  (edge_cfg_i),
            .prio      (prio_i),
            .best      (best[c]),
            .sel       (reg_cpu_i == CPU_W'(c)),
            .wr        (reg_wr_i),
            .rd        (reg_rd_i),
            .addr      (reg_addr_i),
            .wdata     (reg_wdata_i),
            .rdata     (rdata[c]),
            .irq       (cpu_irq_o[c]),
            .clr_v     (clr_v[c]),
            .clr_id    (clr_id[c]),
            .set_v     (set_v[c]),
            .set_id    (set_id[c])
        );
    end

    // unselected ports drive zero, so an OR merges the read data
    always_comb begin
        reg_rdata_o = '0;
        for (int c = 0; c < NUM_CPU; c++) reg_rdata_o |= rdata[c];
    end

    always_comb begin
        for (int c = 0; c < NUM_CPU; c++) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                pend_clr_o[c][i] = 1'b0;
                for (int k = 0; k < NUM_CPU; k++) begin
                    if (clr_v[k] && clr_id[k] == ID_W'(i) && (one_of_n_i[i] || k == c))
                        pend_clr_o[c][i] = 1'b1;
                end
                pend_set_o[c][i] = set_v[c] && (set_id[c] == ID_W'(i));
            end
        end
    end

    // only one CPU interface can accept an acknowledge per cycle
    assert_single_ack_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_v));

endmodule

// File: tb/irq_cpu_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_cpu_arbiter_tb_top;
    localparam int NI = 8;
    localparam int NC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic                   glob_en;
    logic [NC-1:0][NI-1:0]  en, pend, level, target, tb_set, pclr, pset;
    logic [NI-1:0]          edge_cfg, one_of_n;
    logic [NI-1:0][7:0]     prio;
    logic [0:0]             reg_cpu;
    logic                   reg_wr, reg_rd;
    logic [7:0]             reg_addr;
    logic [9:0]             reg_wdata;
    logic [31:0]            reg_rdata;
    logic [NC-1:0]          cpu_irq;

    irq_cpu_arbiter #(.NUM_IRQ(NI), .NUM_CPU(NC)) dut_i (
        .clk(clk), .rst(rst), .glob_en_i(glob_en), .en_i(en), .pend_i(pend),
        .level_i(level), .target_i(target), .edge_cfg_i(edge_cfg),
        .one_of_n_i(one_of_n), .prio_i(prio), .reg_cpu_i(reg_cpu),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .cpu_irq_o(cpu_irq),
        .pend_clr_o(pclr), .pend_set_o(pset)
    );

    // pending-state owner modelled by the bench
    always @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~pclr) | pset | tb_set;
    end

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    typedef struct { int unsigned exp; string tag; } sb_t;
    sb_t sbq[$];

    // monitor: pops one expected item per read strobe
    always begin
        @(negedge clk);
        #1;
        if (reg_rd) begin
            sb_t it;
            it = sbq.pop_front();
            tests++;
            if (reg_rdata != it.exp) begin
                fails++;
                $display("FAIL %s: read actual 0x%0h expected 0x%0h", it.tag, reg_rdata, it.exp);
            end
        end
    end

    task automatic chk(string tag, int unsigned act, int unsigned exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int c, int a, int d);
        @(negedge clk);
        reg_cpu = 1'(c); reg_addr = 8'(a); reg_wdata = 10'(d); reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(int c, int a, int unsigned exp, string tag);
        @(negedge clk);
        reg_cpu = 1'(c); reg_addr = 8'(a); reg_rd = 1'b1;
        sbq.push_back('{exp: exp, tag: tag});
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic raise(int c, int i);
        @(negedge clk);
        tb_set[c][i] = 1'b1;
        @(negedge clk);
        tb_set = '0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        glob_en = 0; en = '1; target = '1; level = '0; tb_set = '0;
        edge_cfg = 8'b1111_1110;          // id0 level-sensitive
        one_of_n = 8'b0000_0010;          // id1 clears for all CPUs
        prio[0] = 8'h80; prio[1] = 8'h40; prio[2] = 8'h40; prio[3] = 8'h20;
        prio[4] = 8'h10; prio[5] = 8'h60; prio[6] = 8'hF0; prio[7] = 8'h08;
        reg_cpu = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        cyc(4);
        rst = 0;

        // R1 reset state
        rd(0, 'h14, 'h100, "R1 running prio");
        rd(0, 'h18, 1023, "R1 highest pending");
        chk("R1 irq low", cpu_irq, 0);
        rd(0, 'h00, 0, "R11 control after reset");

        // R11 register map
        glob_en = 1;
        wr(0, 'h00, 1);
        wr(0, 'h04, 'hFF);
        rd(0, 'h00, 1, "R11 control");
        rd(0, 'h04, 'hFF, "R11 mask");
        wr(0, 'h08, 3);
        rd(0, 'h08, 0, "R11 binary point");
        rd(0, 'h1C, 0, "R11 unmapped");

        // R4 disabled interface on cpu1
        raise(1, 3);
        cyc(2);
        rd(1, 'h18, 1023, "R4 cpu1 disabled");
        chk("R4 cpu1 line", cpu_irq[1], 0);

        // R2 tie on priority 0x40 between id1 and id2
        raise(0, 1); raise(1, 1); raise(0, 2); raise(1, 2);
        cyc(2);
        rd(0, 'h18, 1, "R2 tie lowest index");
        chk("R3 line raised", cpu_irq[0], 1);

        // R3 mask threshold
        wr(0, 'h04, 'h40);
        rd(0, 'h18, 1023, "R3 mask equal");
        cyc(2);
        chk("R3 line masked", cpu_irq[0], 0);
        wr(0, 'h04, 'h41);
        rd(0, 'h18, 1, "R3 mask above");
        wr(0, 'h04, 'hFF);

        // R5 acknowledge, R6 one-of-N clear
        rd(0, 'h0C, 1, "R5 ack id1");
        rd(0, 'h14, 'h40, "R5 running prio");
        chk("R6 one-of-N cpu0", pend[0][1], 0);
        chk("R6 one-of-N cpu1", pend[1][1], 0);
        rd(0, 'h18, 2, "R3 pending at running prio");
        cyc(2);
        chk("R3 no preempt at equal prio", cpu_irq[0], 0);
        rd(0, 'h0C, 1023, "R5 ack refused");

        // nesting 1 -> 3 -> 4
        raise(0, 3);
        cyc(2);
        chk("R3 preempt line", cpu_irq[0], 1);
        rd(0, 'h0C, 3, "R5 ack id3");
        raise(0, 4);
        rd(0, 'h0C, 4, "R5 ack id4");
        rd(0, 'h14, 'h10, "R5 nested prio");

        // R7 out-of-range completion
        wr(0, 'h10, 9);
        rd(0, 'h14, 'h10, "R7 out of range ignored");

        // R10 complete middle of stack
        wr(0, 'h10, 3);
        rd(0, 'h14, 'h10, "R10 running unchanged");
        rd(0, 'h18, 2, "R10 hp unchanged");

        // R9 pop running, predecessor is now id1
        wr(0, 'h10, 4);
        rd(0, 'h14, 'h40, "R9 restored after unlink");
        wr(0, 'h10, 1);
        rd(0, 'h14, 'h100, "R9 back to idle");

        // R6 per-CPU clear, R8 edge not re-pended
        rd(0, 'h0C, 2, "R5 ack id2");
        chk("R6 per-cpu clear own", pend[0][2], 0);
        chk("R6 per-cpu other kept", pend[1][2], 1);
        wr(0, 'h10, 2);
        chk("R8 edge not re-pended", pend[0][2], 0);

        // R8 level re-pend
        level[0][0] = 1;
        raise(0, 0);
        rd(0, 'h0C, 0, "R5 ack id0");
        wr(0, 'h10, 0);
        chk("R8 level re-pended", pend[0][0], 1);
        rd(0, 'h18, 0, "R8 hp after re-pend");
        @(negedge clk);
        level[0][0] = 0;
        rd(0, 'h0C, 0, "R5 ack id0 again");
        wr(0, 'h10, 0);
        chk("R8 deasserted not re-pended", pend[0][0], 0);

        // R7 completion while idle
        @(negedge clk);
        level[0][0] = 1;
        wr(0, 'h10, 0);
        chk("R7 idle completion ignored", pend[0][0], 0);
        rd(0, 'h14, 'h100, "R7 still idle");

        // R4 global enable
        raise(0, 7);
        cyc(2);
        chk("R4 line before gate", cpu_irq[0], 1);
        @(negedge clk);
        glob_en = 0;
        cyc(2);
        rd(0, 'h18, 1023, "R4 global off hp");
        chk("R4 global off line", cpu_irq[0], 0);

        cyc(3);
        done = 1;
        summary();
    end

endmodule